// File: doc/BRIEF.md
# Serial ADC Frame Sequencer (Host Side)

This block is the bus master for a 12-bit converter that is read over a 16-clock serial frame. A request names a power mode (two bits) and an input channel (one bit). The block builds the 8-bit control word from them and drives chip-select, the serial clock and the data line. The serial clock runs at a half-period of `div_half` system clocks. The block shifts the returned bits in and presents the 12-bit result with a one-cycle valid pulse.

The converter samples on the second rising serial-clock edge of a frame. When it has been sitting powered down, it needs a settling time before that edge. The block keeps its own copy of the power mode it last wrote, and it knows the settling interval its divider produces. If that interval is shorter than `WAKE_CYC` system clocks, it first runs an extra frame that writes the always-on mode and drops that frame's data. The real frame follows and writes the requested mode.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, cs_n and sclk are high, mosi is low, res_valid is low, req_ready is high and cur_mode is 00.
- R2: A frame holds cs_n low and sclk high for H system clocks, where H is div_half (0 is treated as 1). It then gives 16 sclk periods that each start with a falling edge, with each half lasting H clocks. It ends H clocks after the 16th rising edge, when cs_n returns high. sclk is high whenever cs_n is high.
- R3: mosi changes only on falling sclk edges. It carries the control word MSB first, valid at rising edges 1 to 8, and is low for rising edges 9 to 16. Control word bits: [7:4] = 0, [3] = channel, [2] = 0, [1:0] = power mode.
- R4: miso is sampled on each rising sclk edge. The result is the last 12 of the 16 bits, MSB first. It is presented on res_data, with the request's channel on res_chan, in the cycle res_valid is high.
- R5: A wake-up frame is inserted exactly when the tracked mode is 00 and 4·H < WAKE_CYC, or the tracked mode is 10 and 3·H < WAKE_CYC. It is never inserted for tracked modes 01 or 11. The wake-up frame writes power mode 01 and the request's channel.
- R6: After a wake-up frame, the real frame starts without a new request. It writes the requested mode and channel, and its data is the result.
- R7: res_valid is high for exactly one cycle per accepted request. It never pulses for a wake-up frame.
- R8: Between two frames, cs_n stays high for at least 2·H system clocks.
- R9: cur_mode changes only in the cycle cs_n rises. It takes the power bits written in the frame that just ended.
- R10: A request is taken when req_valid and req_ready are both high. cs_n is low in the next cycle. req_ready is low whenever cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIVW | sclk half-period in system clocks, latched at request |
| req_valid | input | 1 | Conversion request |
| req_mode | input | 2 | Requested power mode |
| req_chan | input | 1 | Requested input channel |
| req_ready | output | 1 | Block idle, request accepted |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Control word to converter |
| miso | input | 1 | Data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Conversion result |
| res_chan | output | 1 | Channel of the result |
| cur_mode | output | 2 | Power mode the block believes the converter is in |

## Verification
The divider is swept from 0 to 10 with a small settling limit. This places H on both sides of the two thresholds: 4·H for a device left in mode 00 and 3·H for a device left in mode 10. A wrong comparison, or one that uses the wrong edge, shows up as a wrong frame count. Requests walk through all four modes and both channels in a fixed order, so each power mode is met as the tracked state with each of the others requested. This separates a decision based on the tracked mode from one based on the requested mode. The converter model returns a different value in every frame, so data taken from the wake-up frame instead of the real frame is caught. The control word is checked bit by bit for both channel values.

// File: rtl/afs_pkg.sv
package afs_pkg;

  localparam logic [1:0] PM_SHUT   = 2'b00;
  localparam logic [1:0] PM_ON     = 2'b01;
  localparam logic [1:0] PM_AUTOSD = 2'b10;
  localparam logic [1:0] PM_AUTOSB = 2'b11;

  typedef logic [7:0] ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_st_e;

  // control word sent MSB first: channel at bit 3, power bits at [1:0]
  function automatic ctl_t ctl_word(input logic [1:0] pm, input logic ch);
    return {4'b0000, ch, 1'b0, pm};
  endfunction

  // system clocks from the wake reference point to the sampling edge
  function automatic int unsigned settle_cycles(input logic [1:0] pm,
                                                input int unsigned half);
    case (pm)
      PM_SHUT:   return 4 * half;   // from chip-select falling
      PM_AUTOSD: return 3 * half;   // from first falling sclk
      default:   return 0;
    endcase
  endfunction

  function automatic logic wake_required(input logic [1:0] pm,
                                         input int unsigned half,
                                         input int unsigned need);
    return ((pm == PM_SHUT) || (pm == PM_AUTOSD)) &&
           (settle_cycles(pm, half) < need);
  endfunction

endpackage

// File: rtl/afs_halftimer.sv
module afs_halftimer #(
  parameter int DIVW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [DIVW-1:0] half,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = !clear && (cnt == half - DIVW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                    cnt <= cnt + DIVW'(1);
  end
endmodule

// File: rtl/afs_shifter.sv
module afs_shifter #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             fall_ev,
  input  logic             rise_ev,
  input  logic             miso,
  output logic             mosi,
  output logic [RES_W-1:0] rx
);
  logic [7:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx   <= '0;
      mosi <= 1'b0;
      rx   <= '0;
    end else begin
      if (load) begin
        tx <= load_byte;
        rx <= '0;
      end else begin
        if (fall_ev) {mosi, tx} <= {tx, 1'b0};
        if (rise_ev) rx <= {rx[RES_W-2:0], miso};
      end
    end
  end
endmodule

// File: rtl/afs_ctrl.sv
module afs_ctrl
  import afs_pkg::*;
#(
  parameter int          DIVW     = 10,
  parameter int          FRW      = 16,
  parameter int          RES_W    = 12,
  parameter int unsigned WAKE_CYC = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIVW-1:0]  div_half,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             req_chan,
  output logic             req_ready,
  input  logic             tick,
  output logic             tmr_clear,
  output logic [DIVW-1:0]  half_q,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             load_ev,
  output logic [7:0]       load_byte,
  input  logic [RES_W-1:0] rx_res,
  output logic             cs_n,
  output logic             sclk,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_chan,
  output logic [1:0]       cur_mode,
  output logic             wake_active
);
  localparam int EDGES = 2 * FRW;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  seq_st_e         state;
  logic [EW-1:0]   edge_idx;
  logic            gap_second;
  logic [1:0]      mode_q;
  logic            chan_q;
  logic            wake_q;
  logic [1:0]      bel_q;
  logic [DIVW-1:0] div_eff;
  logic            wake_need;
  logic            accept;
  logic            restart;

  assign div_eff   = (div_half == '0) ? DIVW'(1) : div_half;
  assign wake_need = wake_required(bel_q, 32'(div_eff), WAKE_CYC);
  assign accept    = (state == ST_IDLE) && req_valid;
  assign restart   = (state == ST_GAP) && tick && gap_second && wake_q;

  assign req_ready   = (state == ST_IDLE);
  assign tmr_clear   = (state == ST_IDLE);
  assign fall_ev     = tick && ((state == ST_LEAD) ||
                                ((state == ST_SHIFT) && !edge_idx[0]));
  assign rise_ev     = tick && (state == ST_SHIFT) && edge_idx[0];
  assign load_ev     = accept || restart;
  assign load_byte   = restart   ? ctl_word(mode_q, chan_q) :
                       wake_need ? ctl_word(PM_ON, req_chan) :
                                   ctl_word(req_mode, req_chan);
  assign cur_mode    = bel_q;
  assign wake_active = wake_q && (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      edge_idx   <= '0;
      gap_second <= 1'b0;
      half_q     <= DIVW'(1);
      mode_q     <= PM_SHUT;
      chan_q     <= 1'b0;
      wake_q     <= 1'b0;
      bel_q      <= PM_SHUT;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_chan   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_LEAD;
            cs_n   <= 1'b0;
            half_q <= div_eff;
            mode_q <= req_mode;
            chan_q <= req_chan;
            wake_q <= wake_need;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state    <= ST_SHIFT;
            sclk     <= 1'b0;
            edge_idx <= EW'(1);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk     <= edge_idx[0];
            edge_idx <= edge_idx + EW'(1);
            if (edge_idx == LAST_EDGE) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state      <= ST_GAP;
            cs_n       <= 1'b1;
            gap_second <= 1'b0;
            bel_q      <= wake_q ? PM_ON : mode_q;
            res_valid  <= !wake_q;
            res_data   <= rx_res;
            res_chan   <= chan_q;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (!gap_second) begin
              gap_second <= 1'b1;
            end else if (wake_q) begin
              state  <= ST_LEAD;
              cs_n   <= 1'b0;
              wake_q <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int          DIVW     = 10,
  parameter int          FRW      = 16,
  parameter int          RES_W    = 12,
  parameter int unsigned WAKE_CYC = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIVW-1:0]  div_half,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             req_chan,
  output logic             req_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_chan,
  output logic [1:0]       cur_mode
);
  logic            tick;
  logic            tmr_clear;
  logic [DIVW-1:0] half_q;
  logic            fall_ev;
  logic            rise_ev;
  logic            load_ev;
  logic [7:0]      load_byte;
  logic [RES_W-1:0] rx_res;
  logic            wake_active;

  afs_halftimer #(.DIVW(DIVW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .half  (half_q),
    .tick  (tick)
  );

  afs_ctrl #(
    .DIVW(DIVW), .FRW(FRW), .RES_W(RES_W), .WAKE_CYC(WAKE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_half    (div_half),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_chan    (req_chan),
    .req_ready   (req_ready),
    .tick        (tick),
    .tmr_clear   (tmr_clear),
    .half_q      (half_q),
    .fall_ev     (fall_ev),
    .rise_ev     (rise_ev),
    .load_ev     (load_ev),
    .load_byte   (load_byte),
    .rx_res      (rx_res),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .cur_mode    (cur_mode),
    .wake_active (wake_active)
  );

  afs_shifter #(.RES_W(RES_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .load_byte (load_byte),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .miso      (miso),
    .mosi      (mosi),
    .rx        (rx_res)
  );
endmodule

// File: rtl/afs_checker.sv
module afs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       req_valid,
  input logic       req_ready,
  input logic       res_valid,
  input logic       wake_active,
  input logic [1:0] cur_mode
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n);

  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  // R7
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  no_wake_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !wake_active);

  // R3
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $fell(sclk));

  // R9
  mode_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> $rose(cs_n));
endmodule

bind adc_frame_seq afs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .mosi        (mosi),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .res_valid   (res_valid),
  .wake_active (wake_active),
  .cur_mode    (cur_mode)
);

// File: tb/adc_frame_seq_tb.sv
`timescale 1ns/1ps
module adc_frame_seq_tb;
  localparam int DIVW = 4;
  localparam int RES_W = 12;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIVW-1:0] div_half = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic req_chan = 1'b0;
  logic req_ready, cs_n, sclk, mosi, res_valid, res_chan;
  logic miso = 1'b0;
  logic [RES_W-1:0] res_data;
  logic [1:0] cur_mode;

  always #2 clk = ~clk;

  adc_frame_seq #(.DIVW(DIVW), .RES_W(RES_W), .WAKE_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .req_valid(req_valid),
    .req_mode(req_mode), .req_chan(req_chan), .req_ready(req_ready),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .cur_mode(cur_mode)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dev_val(input int n);
    return (n * 1237 + 291) % 4096;
  endfunction

  // converter model and frame log
  int nfr = 0, nfall = 0, nrise = 0;
  int t_csf = 0, t_csr = 0, t_f1 = 0, t_r1 = 0, t_r2 = 0;
  bit started = 0;
  logic [15:0] word;
  logic [7:0] cbyte;
  int fr_ctl[0:255], fr_half[0:255], fr_lead[0:255], fr_csh[0:255];
  int fr_s00[0:255], fr_s10[0:255], fr_tail[0:255];

  always @(negedge cs_n) begin
    started = 1;
    fr_csh[nfr] = cyc - t_csr;
    t_csf = cyc; nfall = 0; nrise = 0; cbyte = '0;
    word = {4'b0000, 12'(dev_val(nfr))};
  end
  always @(posedge cs_n) if (started) begin
    fr_ctl[nfr]  = int'(cbyte);
    fr_half[nfr] = t_r1 - t_f1;
    fr_lead[nfr] = t_f1 - t_csf;
    fr_s00[nfr]  = t_r2 - t_csf;
    fr_s10[nfr]  = t_r2 - t_f1;
    fr_tail[nfr] = (nrise == 16 && nfall == 16) ? 1 : 0;
    t_csr = cyc;
    nfr = nfr + 1;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    if (nfall == 0) t_f1 = cyc;
    if (nfall < 16) miso = word[15 - nfall];
    nfall = nfall + 1;
  end
  always @(posedge sclk) if (cs_n === 1'b0) begin
    if (nrise < 8) cbyte = {cbyte[6:0], mosi};
    else if (mosi !== 1'b0) cbyte = 8'hFF;  // R3: must be low after word
    if (nrise == 0) t_r1 = cyc;
    if (nrise == 1) t_r2 = cyc;
    nrise = nrise + 1;
  end

  int npulse = 0;
  int got_data = 0, got_chan = 0;
  always @(negedge clk) if (rst_n && res_valid) begin
    npulse = npulse + 1;
    got_data = int'(res_data);
    got_chan = int'(res_chan);
  end

  int tb_bel = 0;

  task automatic run_req(input int d, input int m, input int c);
    int f0, p0, de, nexp, lastf;
    bit exp_wake, tim_ok;
    de = (d == 0) ? 1 : d;
    exp_wake = (tb_bel == 0 && 4 * de < W) || (tb_bel == 2 && 3 * de < W);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    f0 = nfr; p0 = npulse;
    div_half = DIVW'(d); req_mode = 2'(m); req_chan = 1'(c); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(cs_n == 1'b0, "R10 cs_n low after accept", int'(cs_n), 0);
    while (npulse == p0) @(negedge clk);
    while (!req_ready) @(negedge clk);
    nexp = exp_wake ? 2 : 1;
    lastf = nfr - 1;
    check(nfr - f0 == nexp, "R5 frames per request", nfr - f0, nexp);
    check(fr_ctl[lastf] == c * 8 + m, "R3/R6 control word", fr_ctl[lastf], c * 8 + m);
    if (exp_wake)
      check(fr_ctl[f0] == c * 8 + 1, "R5 wake control word", fr_ctl[f0], c * 8 + 1);
    check(got_data == dev_val(lastf), "R4 result data", got_data, dev_val(lastf));
    check(got_chan == c, "R4 result channel", got_chan, c);
    check(npulse == p0 + 1, "R7 one pulse per request", npulse - p0, 1);
    check(int'(cur_mode) == m, "R9 tracked mode", int'(cur_mode), m);
    tim_ok = 1;
    for (int f = f0; f <= lastf; f++) begin
      if (fr_half[f] != de || fr_lead[f] != de || fr_tail[f] != 1) tim_ok = 0;
      if (f > 0 && fr_csh[f] < 2 * de) tim_ok = 0;
    end
    check(tim_ok, "R2/R8 frame timing", fr_half[lastf], de);
    if (!exp_wake && tb_bel == 0)
      check(fr_s00[f0] >= W, "R5 settle from cs fall", fr_s00[f0], W);
    if (!exp_wake && tb_bel == 2)
      check(fr_s10[f0] >= W, "R5 settle from first fall", fr_s10[f0], W);
    tb_bel = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1 && sclk == 1'b1, "R1 cs_n/sclk idle", int'({cs_n, sclk}), 3);
    check(mosi == 1'b0 && res_valid == 1'b0, "R1 mosi/res_valid", int'({mosi, res_valid}), 0);
    check(req_ready == 1'b1 && cur_mode == 2'b00, "R1 ready/mode", int'({req_ready, cur_mode}), 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d <= 10; d++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          run_req(d, m, c);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule